// File: doc/BRIEF.md
# Reference Clock Frequency Qualifier

This block decides, for each of several reference clock inputs, whether the reference is running close enough to its nominal frequency to be trusted. Each reference first passes through a flop synchroniser into the system clock domain. A detector then turns every rising edge into a one-cycle pulse, and a per-channel counter adds up those pulses over a gate window of fixed length that all channels share.

When a gate closes, the count is placed in one of three bands, using four bounds that the integrator sets for each channel. A count inside the narrow window grants qualification. A count outside the wide window revokes it. A count in the ring between the two windows leaves the previous verdict in place. This hysteresis stops a reference that sits near a limit from toggling the verdict. Every channel runs all the time, so the standby reference is judged exactly like the one in use.

The fail indicator is active low. It drops in the same cycle that qualification is lost and stays low until a refresh boundary, which comes once every several gates. It returns high only at such a boundary, and only if the channel is qualified there.

Top module: `freq_qual_top`

## Requirements
- R1: While reset is held and immediately after it, every channel has `freq_ok` = 0 and `fail_n` = 0. A channel stays unqualified until a gate has closed with an in-window count.
- R2: Each rising edge of a reference adds exactly one to that channel's count, after a synchroniser of SYNC_STAGES flops. The count is evaluated and cleared once every GATE_CYC system cycles. An edge that arrives in the closing cycle belongs to the closing gate.
- R3: If a gate closes with a count c where inner_lo <= c <= inner_hi, `freq_ok` is 1 in the following cycle.
- R4: If a gate closes with c < outer_lo or c > outer_hi, `freq_ok` is 0 in the following cycle.
- R5: If a gate closes with a count inside the outer bounds but outside the inner bounds, `freq_ok` keeps its previous value.
- R6: `freq_ok` changes only in the cycle after a gate closes.
- R7: A reference that has stopped produces a count of zero, which lies below outer_lo, so the channel becomes disqualified.
- R8: `fail_n` is 0 whenever `freq_ok` is 0. It falls in the same cycle as `freq_ok`.
- R9: `fail_n` rises only in the cycle after a refresh gate, which is every REFRESH_GATES-th gate. It rises then only if the channel is qualified. The number of cycles from the rise of `freq_ok` to the rise of `fail_n` is therefore a multiple of GATE_CYC and is less than REFRESH_GATES*GATE_CYC.
- R10: Each channel is qualified from its own reference and its own bounds, whatever the other channels do.
- R11: The edge counter saturates at its all-ones value and does not wrap within a gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | NUM_REF | Reference clocks, asynchronous to clk |
| inner_lo | input | NUM_REF*CNT_W | Per-channel lowest count that grants qualification |
| inner_hi | input | NUM_REF*CNT_W | Per-channel highest count that grants qualification |
| outer_lo | input | NUM_REF*CNT_W | Per-channel counts below this revoke qualification |
| outer_hi | input | NUM_REF*CNT_W | Per-channel counts above this revoke qualification |
| freq_ok | output | NUM_REF | Per-channel qualification state |
| fail_n | output | NUM_REF | Per-channel latched fail flag, active low |

## Verification
The assertions assume that, for every channel, the bounds are static and ordered so that outer_lo <= inner_lo <= inner_hi <= outer_hi. They also assume that a reference is never faster than half the system clock, so the synchroniser sees every level. The bench sets the bounds once before reset is released and never changes them. It produces each reference with a phase accumulator clocked by the system clock, so the edge rate is at most half that clock. It also chooses rates that sit at least one count clear of every bound, so that either rounding of a gate's count lands in the same band. Every frequency step is held for three gates, and the sequences are ordered so that the one mixed gate in a transition can never fall in a band that would change the final verdict.

// File: rtl/freq_qual_pkg.sv
package freq_qual_pkg;

   typedef enum logic [1:0] {
      BAND_INNER = 2'd0,
      BAND_RING  = 2'd1,
      BAND_OUTER = 2'd2
   } band_e;

   // Place a closed-gate count in one of the three hysteresis bands.
   function automatic band_e classify(input logic [31:0] c,
                                      input logic [31:0] in_lo,
                                      input logic [31:0] in_hi,
                                      input logic [31:0] out_lo,
                                      input logic [31:0] out_hi);
      if (c >= in_lo && c <= in_hi)
         return BAND_INNER;
      else if (c < out_lo || c > out_hi)
         return BAND_OUTER;
      else
         return BAND_RING;
   endfunction

endpackage

// File: rtl/fq_edge_sync.sv
module fq_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic edge_pulse
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fq_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // One flop beyond the synchroniser keeps the previous level for edge detection.
   logic [SYNC_STAGES:0] shr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shr <= '0;
      else
         shr <= {shr[SYNC_STAGES-1:0], ref_in};
   end

   assign edge_pulse = shr[SYNC_STAGES-1] & ~shr[SYNC_STAGES];

   // R2: consecutive pulses are impossible, so no edge is merged into another
   a_r2_pulse_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/fq_gate_timer.sv
module fq_gate_timer #(
   parameter int GATE_CYC      = 2048,
   parameter int REFRESH_GATES = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic gate_end,
   output logic refresh
);

   localparam int GW = (GATE_CYC > 2) ? $clog2(GATE_CYC) : 1;
   localparam int RW = (REFRESH_GATES > 2) ? $clog2(REFRESH_GATES) : 1;
   localparam logic [GW-1:0] G_LAST = GW'(GATE_CYC - 1);
   localparam logic [RW-1:0] R_LAST = RW'(REFRESH_GATES - 1);

   generate
      if (GATE_CYC < 2) begin : g_bad_gate
         $error("fq_gate_timer: GATE_CYC must be at least 2");
      end
      if (REFRESH_GATES < 1) begin : g_bad_refresh
         $error("fq_gate_timer: REFRESH_GATES must be at least 1");
      end
   endgenerate

   logic [GW-1:0] gcnt;
   logic [RW-1:0] rcnt;

   assign gate_end = (gcnt == G_LAST);

   generate
      if (REFRESH_GATES == 1) begin : g_refresh_every
         assign refresh = gate_end;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rcnt <= '0;
            else        rcnt <= '0;
         end
      end else begin : g_refresh_div
         assign refresh = gate_end && (rcnt == R_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rcnt <= '0;
            else if (gate_end)
               rcnt <= (rcnt == R_LAST) ? '0 : rcnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gcnt <= '0;
      else if (gate_end)
         gcnt <= '0;
      else
         gcnt <= gcnt + 1'b1;
   end

   // R2: gate counter never passes its last value
   a_r2_gate_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      gcnt <= G_LAST);
   // R9: refresh only ever coincides with a gate end
   a_r9_refresh_on_gate: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |-> gate_end);

endmodule

// File: rtl/fq_meter.sv
module fq_meter
   import freq_qual_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_pulse,
   input  logic             gate_end,
   input  logic             refresh,
   input  logic [CNT_W-1:0] in_lo,
   input  logic [CNT_W-1:0] in_hi,
   input  logic [CNT_W-1:0] out_lo,
   input  logic [CNT_W-1:0] out_hi,
   output logic             freq_ok,
   output logic             fail_n
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("fq_meter: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] meas;
   logic             sat;
   band_e            band;
   logic             ok_nxt;

   assign sat  = &cnt;
   assign meas = (edge_pulse && !sat) ? cnt + 1'b1 : cnt;
   assign band = classify(32'(meas), 32'(in_lo), 32'(in_hi), 32'(out_lo), 32'(out_hi));

   always_comb begin
      unique case (band)
         BAND_INNER: ok_nxt = 1'b1;
         BAND_OUTER: ok_nxt = 1'b0;
         default:    ok_nxt = freq_ok;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         freq_ok <= 1'b0;
         fail_n  <= 1'b0;
      end else if (gate_end) begin
         cnt     <= '0;
         freq_ok <= ok_nxt;
         if (!ok_nxt)
            fail_n <= 1'b0;
         else if (refresh)
            fail_n <= 1'b1;
      end else begin
         cnt <= meas;
      end
   end

   a_r2_counts_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_end && edge_pulse && !sat) |=> (cnt == $past(cnt) + 1'b1));
   a_r3_inner_grants: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_end && meas >= in_lo && meas <= in_hi) |=> freq_ok);
   a_r4_outer_revokes: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_end && (meas < out_lo || meas > out_hi)) |=> !freq_ok);
   a_r5_ring_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_end && meas >= out_lo && meas <= out_hi && (meas < in_lo || meas > in_hi))
      |=> $stable(freq_ok));
   a_r6_only_at_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_end |=> $stable(freq_ok));
   a_r8_fail_when_unqual: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_ok |-> !fail_n);
   a_r9_rise_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_n) |-> ($past(refresh) && freq_ok));
   a_r11_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_end && sat) |=> sat);

endmodule

// File: rtl/freq_qual_top.sv
module freq_qual_top #(
   parameter int NUM_REF       = 2,
   parameter int CNT_W         = 12,
   parameter int GATE_CYC      = 2048,
   parameter int REFRESH_GATES = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_REF-1:0]       ref_clk,
   input  logic [NUM_REF*CNT_W-1:0] inner_lo,
   input  logic [NUM_REF*CNT_W-1:0] inner_hi,
   input  logic [NUM_REF*CNT_W-1:0] outer_lo,
   input  logic [NUM_REF*CNT_W-1:0] outer_hi,
   output logic [NUM_REF-1:0]       freq_ok,
   output logic [NUM_REF-1:0]       fail_n
);

   generate
      if (NUM_REF < 1) begin : g_bad_num
         $error("freq_qual_top: NUM_REF must be at least 1");
      end
      if (GATE_CYC >= (1 << (CNT_W < 31 ? CNT_W : 30)) * 2 && CNT_W < 31) begin : g_note_sat
         // Gate may see more edges than the counter holds; the counter saturates.
      end
   endgenerate

   logic gate_end;
   logic refresh;

   fq_gate_timer #(
      .GATE_CYC      (GATE_CYC),
      .REFRESH_GATES (REFRESH_GATES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_end (gate_end),
      .refresh  (refresh)
   );

   for (genvar i = 0; i < NUM_REF; i++) begin : g_ch
      logic edge_pulse;

      fq_edge_sync #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_sync (
         .clk        (clk),
         .rst_n      (rst_n),
         .ref_in     (ref_clk[i]),
         .edge_pulse (edge_pulse)
      );

      fq_meter #(
         .CNT_W (CNT_W)
      ) u_meter (
         .clk        (clk),
         .rst_n      (rst_n),
         .edge_pulse (edge_pulse),
         .gate_end   (gate_end),
         .refresh    (refresh),
         .in_lo      (inner_lo[i*CNT_W +: CNT_W]),
         .in_hi      (inner_hi[i*CNT_W +: CNT_W]),
         .out_lo     (outer_lo[i*CNT_W +: CNT_W]),
         .out_hi     (outer_hi[i*CNT_W +: CNT_W]),
         .freq_ok    (freq_ok[i]),
         .fail_n     (fail_n[i])
      );
   end

   // R1: nothing is qualified in the first cycle after reset
   a_r1_reset_unqual: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (freq_ok == '0 && fail_n == '0));

endmodule

// File: tb/tb_freq_qual_top.sv
module tb_freq_qual_top;

   localparam int NUM_REF = 2;
   localparam int CNT_W   = 8;
   localparam int GATE    = 200;
   localparam int REFR    = 4;
   localparam int NSTEP   = 10;
   localparam int IN_LO = 49, IN_HI = 51, OUT_LO = 46, OUT_HI = 54;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_REF-1:0] ref_clk = '0;
   logic [NUM_REF*CNT_W-1:0] inner_lo, inner_hi, outer_lo, outer_hi;
   logic [NUM_REF-1:0] freq_ok, fail_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   freq_qual_top #(
      .NUM_REF (NUM_REF), .CNT_W (CNT_W), .GATE_CYC (GATE),
      .REFRESH_GATES (REFR), .SYNC_STAGES (2)
   ) dut (
      .clk (clk), .rst_n (rst_n), .ref_clk (ref_clk),
      .inner_lo (inner_lo), .inner_hi (inner_hi),
      .outer_lo (outer_lo), .outer_hi (outer_hi),
      .freq_ok (freq_ok), .fail_n (fail_n)
   );

   // Phase accumulators: rate of edges per gate = inc * GATE / 65536
   logic [15:0] acc [NUM_REF];
   logic [15:0] inc [NUM_REF];

   always @(negedge clk) begin
      for (int i = 0; i < NUM_REF; i++) begin
         acc[i] <= acc[i] + inc[i];
         ref_clk[i] <= acc[i][15];
      end
   end

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // Band of a rate, with a one-count margin so either rounding gives the same band
   function automatic int band_of(input logic [15:0] v);
      real r;
      r = real'(v) * GATE / 65536.0;
      if (r >= IN_LO + 1 && r <= IN_HI - 1) return 0;
      if (r < OUT_LO - 1 || r > OUT_HI + 1) return 2;
      return 1;
   endfunction

   // Continuous monitor of the latched fail flag (R8, R9)
   int ok_wait [NUM_REF];
   logic [NUM_REF-1:0] fail_prev;
   int r8_viol = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NUM_REF; i++) begin
            if (!freq_ok[i] && fail_n[i]) r8_viol++;
            if (fail_n[i] && !fail_prev[i]) begin
               // R9: gap from qualification to flag release
               check("R9 release gap multiple of gate", ok_wait[i] % GATE, 0);
               check("R9 release gap below refresh period",
                     int'(ok_wait[i] < REFR * GATE), 1);
            end
            if (freq_ok[i] && !fail_n[i]) ok_wait[i]++;
            else ok_wait[i] = 0;
         end
      end
      fail_prev <= fail_n;
   end

   initial begin
      automatic logic [15:0] tab0 [NSTEP] = '{16384, 17203, 18678, 17203, 16384,
                                              15565, 14090, 15565, 16384, 0};
      automatic logic [15:0] tab1 [NSTEP] = '{18678, 16384, 17203, 15565, 14090,
                                              16384, 18678, 17203, 16384, 0};
      automatic int exp0 = 0;
      automatic int exp1 = 0;
      for (int i = 0; i < NUM_REF; i++) begin
         inner_lo[i*CNT_W +: CNT_W] = CNT_W'(IN_LO);
         inner_hi[i*CNT_W +: CNT_W] = CNT_W'(IN_HI);
         outer_lo[i*CNT_W +: CNT_W] = CNT_W'(OUT_LO);
         outer_hi[i*CNT_W +: CNT_W] = CNT_W'(OUT_HI);
         acc[i] = '0;
         inc[i] = '0;
         ok_wait[i] = 0;
      end
      fail_prev = '0;
      repeat (5) @(negedge clk);
      // R1: state during reset
      check("R1 freq_ok in reset", int'(freq_ok), 0);
      check("R1 fail_n in reset", int'(fail_n), 0);
      inc[0] = tab0[0];
      inc[1] = tab1[0];
      rst_n = 1'b1;
      repeat (GATE / 2) @(negedge clk);
      // R1: a good reference is not qualified before the first gate closes
      check("R1 unqualified before first gate", int'(freq_ok[0]), 0);
      check("R1 fail_n low before first gate", int'(fail_n[0]), 0);
      for (int s = 0; s < NSTEP; s++) begin
         inc[0] = tab0[s];
         inc[1] = tab1[s];
         repeat (3 * GATE + 10) @(negedge clk);
         case (band_of(tab0[s]))
            0: exp0 = 1;
            2: exp0 = 0;
            default: ;
         endcase
         case (band_of(tab1[s]))
            0: exp1 = 1;
            2: exp1 = 0;
            default: ;
         endcase
         // R3 grant, R4 revoke, R5 ring hold, R7 stopped reference, R10 independence
         check($sformatf("R3/R4/R5/R7 ch0 step %0d", s), int'(freq_ok[0]), exp0);
         check($sformatf("R10 ch1 step %0d (R3/R4/R5)", s), int'(freq_ok[1]), exp1);
         // R8: an unqualified channel always shows its fail flag
         if (exp0 == 0) check($sformatf("R8 ch0 step %0d", s), int'(fail_n[0]), 0);
         if (exp1 == 0) check($sformatf("R8 ch1 step %0d", s), int'(fail_n[1]), 0);
         // R9: held qualification is released within one refresh period
         if (s > 0 && exp0 == 1 && freq_ok[0]) begin
            repeat (REFR * GATE) @(negedge clk);
            check($sformatf("R9 ch0 released step %0d", s), int'(fail_n[0]), 1);
         end
      end
      check("R8 flag never high while unqualified", r8_viol, 0);
      done = 1;
   end

   // R2 and R11 are covered by assertions on the counter and synchroniser
   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(negedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule